// File: doc/BRIEF.md
# Serial Line Code Encoder

This block turns a plain non-return-to-zero bit stream into one of four line codes: NRZ pass-through, NRZI (level transitions mark ones), return-to-zero, or Manchester (biphase). It runs from a clock at twice the bit rate, so every bit period is split into a first-half slot and a second-half slot. A strobe output tells the data source which cycle to present the next bit in. The encoded output comes only from registers, which makes the block a Moore machine. The line therefore carries no combinational glitches from the data or mode inputs.

The mode and the data bit are captured together at the sampling edge, and both are held for the whole bit period. Changing either one halfway through a bit has no effect until the next bit period. A single level register stores the last NRZI level. Only NRZI bits update it, so an NRZI stream resumes from its earlier line level after a period spent in another mode.

Top module: `line_code_encoder`

## Requirements
- R1: While reset is high, and in the first cycle after it, `line_out` is 0 and `bit_strobe` is 1. Reset also clears the stored NRZI level to 0, so the first NRZI data 0 after reset drives 0.
- R2: `bit_strobe` is high in every other cycle, starting with the first cycle after reset, and marks the first-half slot. `mode` and `nrz_in` are sampled at the rising edge that ends a cycle in which `bit_strobe` is high.
- R3: The first-half level of a sampled bit appears on `line_out` in the cycle right after the sampling edge. The second-half level appears in the cycle after that.
- R4: With `mode` = 2'b00 (NRZ), `line_out` equals the data bit in both halves.
- R5: With `mode` = 2'b01 (NRZI), a data 0 drives the stored level unchanged in both halves.
- R6: With `mode` = 2'b01 (NRZI), a data 1 drives the complement of the stored level in both halves, and that complement becomes the new stored level.
- R7: With `mode` = 2'b10 (RZ), a data 0 drives 0 in both halves.
- R8: With `mode` = 2'b10 (RZ), a data 1 drives 1 in the first half and 0 in the second.
- R9: With `mode` = 2'b11 (Manchester), a data 0 drives 0 then 1, and a data 1 drives 1 then 0.
- R10: Changes to `mode` or `nrz_in` in the cycle after the sampling edge do not change the second half of the bit in progress.
- R11: Bits sent in NRZ, RZ or Manchester mode leave the stored NRZI level unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Line code select: 00 NRZ, 01 NRZI, 10 RZ, 11 Manchester |
| nrz_in | input | 1 | Data bit, sampled when `bit_strobe` is high |
| bit_strobe | output | 1 | High in the cycle where the next bit is to be presented |
| line_out | output | 1 | Registered encoded serial output |

## Verification
Each result has a fixed arrival time. A bit's first half is due one cycle after its sampling edge and its second half two cycles after. The strobe returns high in that same second cycle, ready for the next bit. The bench drives inputs on falling edges. It samples `line_out` on the first and second falling edges after the sampling edge, so each observation sits in the middle of the slot it checks. The strobe is checked in both slots of every bit, and each check is tied to the edge count above, not to a settling delay.

// File: rtl/lc_pkg.sv
package lc_pkg;

    localparam int LC_SLOTS_PER_BIT = 2;

    typedef enum logic [1:0] {
        LC_NRZ   = 2'b00,
        LC_NRZI  = 2'b01,
        LC_RZ    = 2'b10,
        LC_MANCH = 2'b11
    } lc_mode_e;

    typedef struct packed {
        logic first;
        logic second;
    } lc_halves_t;

    typedef struct packed {
        lc_halves_t halves;
        logic       level_next;
    } lc_enc_t;

    // Map one data bit to its two half-bit levels and the next NRZI level.
    function automatic lc_enc_t lc_encode(lc_mode_e m, logic d, logic level);
        lc_enc_t r;
        r.level_next = level;
        unique case (m)
            LC_NRZ: begin
                r.halves.first  = d;
                r.halves.second = d;
            end
            LC_NRZI: begin
                r.level_next    = level ^ d;
                r.halves.first  = level ^ d;
                r.halves.second = level ^ d;
            end
            LC_RZ: begin
                r.halves.first  = d;
                r.halves.second = 1'b0;
            end
            LC_MANCH: begin
                r.halves.first  = d;
                r.halves.second = ~d;
            end
            default: begin
                r.halves.first  = 1'b0;
                r.halves.second = 1'b0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lc_phase_gen.sv
module lc_phase_gen #(
    parameter int SLOTS = 2
) (
    input  logic clk,
    input  logic rst,
    output logic first_slot,
    output logic last_slot
);
    localparam int CW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign first_slot = (cnt_q == '0);
    assign last_slot  = (cnt_q == LAST);
endmodule

// File: rtl/lc_symbol_enc.sv
module lc_symbol_enc
    import lc_pkg::*;
#(
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  lc_mode_e   mode,
    input  logic       data,
    output lc_halves_t halves
);
    logic    level_q;
    lc_enc_t enc;

    always_comb begin
        enc    = lc_encode(mode, data, level_q);
        halves = enc.halves;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= RESET_LEVEL;
        end else if (load) begin
            level_q <= enc.level_next;
        end
    end
endmodule

// File: rtl/lc_out_stage.sv
module lc_out_stage
    import lc_pkg::*;
#(
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       advance,
    input  lc_halves_t halves,
    output logic       line
);
    logic line_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= RESET_LEVEL;
            pend_q <= RESET_LEVEL;
        end else if (load) begin
            line_q <= halves.first;
            pend_q <= halves.second;
        end else if (advance) begin
            line_q <= pend_q;
        end
    end

    assign line = line_q;
endmodule

// File: rtl/line_code_encoder.sv
module line_code_encoder
    import lc_pkg::*;
#(
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       nrz_in,
    output logic       bit_strobe,
    output logic       line_out
);
    logic       first_slot;
    logic       last_slot;
    lc_halves_t halves;

    lc_phase_gen #(.SLOTS(LC_SLOTS_PER_BIT)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .first_slot (first_slot),
        .last_slot  (last_slot)
    );

    lc_symbol_enc #(.RESET_LEVEL(RESET_LEVEL)) u_enc (
        .clk    (clk),
        .rst    (rst),
        .load   (first_slot),
        .mode   (lc_mode_e'(mode)),
        .data   (nrz_in),
        .halves (halves)
    );

    lc_out_stage #(.RESET_LEVEL(RESET_LEVEL)) u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (first_slot),
        .advance (last_slot),
        .halves  (halves),
        .line    (line_out)
    );

    assign bit_strobe = first_slot;
endmodule

// File: rtl/lc_checker.sv
module lc_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       nrz_in,
    input logic       bit_strobe,
    input logic       line_out
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!line_out && bit_strobe));

    assert_strobe_rise_R2: assert property (@(posedge clk) disable iff (rst)
        !bit_strobe |=> bit_strobe);

    assert_strobe_fall_R2: assert property (@(posedge clk) disable iff (rst)
        bit_strobe |=> !bit_strobe);

    assert_nrz_follow_R4: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe && mode == 2'b00) |=>
            (line_out == $past(nrz_in)) ##1 (line_out == $past(nrz_in, 2)));

    assert_nrzi_flat_R5: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe && mode == 2'b01) |=> ##1 $stable(line_out));

    assert_rz_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe && mode == 2'b10 && !nrz_in) |=> !line_out ##1 !line_out);

    assert_rz_one_R8: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe && mode == 2'b10 && nrz_in) |=> line_out ##1 !line_out);

    assert_manch_R9: assert property (@(posedge clk) disable iff (rst)
        (bit_strobe && mode == 2'b11) |=>
            (line_out == $past(nrz_in)) ##1 (line_out != $past(nrz_in, 2)));
endmodule

bind line_code_encoder lc_checker u_lc_checker (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .nrz_in     (nrz_in),
    .bit_strobe (bit_strobe),
    .line_out   (line_out)
);

// File: tb/tb_line_code_encoder.sv
module tb_line_code_encoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       nrz_in = 1'b0;
    logic       bit_strobe;
    logic       line_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic lvl_m = 1'b0;   // bench copy of the stored NRZI level

    always #2.5 clk = ~clk;   // 200 MHz

    line_code_encoder dut (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .nrz_in     (nrz_in),
        .bit_strobe (bit_strobe),
        .line_out   (line_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Expected half levels, taken from the requirements.
    task automatic expect_halves(input logic [1:0] m, input logic b,
                                 output logic e1, output logic e2);
        case (m)
            2'b00: begin e1 = b; e2 = b; end
            2'b01: begin lvl_m = lvl_m ^ b; e1 = lvl_m; e2 = lvl_m; end
            2'b10: begin e1 = b; e2 = 1'b0; end
            default: begin e1 = b; e2 = ~b; end
        endcase
    endtask

    // Call at a falling edge with bit_strobe high.
    task automatic xmit(input logic [1:0] m, input logic b, input string req);
        logic e1, e2;
        expect_halves(m, b, e1, e2);
        check("R2 strobe in first slot", bit_strobe, 1'b1);
        mode = m; nrz_in = b;
        @(posedge clk); @(negedge clk);
        check({req, " first half (R3)"}, line_out, e1);
        check("R2 strobe low in second slot", bit_strobe, 1'b0);
        @(posedge clk); @(negedge clk);
        check({req, " second half (R3)"}, line_out, e2);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 line low in reset", line_out, 1'b0);
        check("R1 strobe high in reset", bit_strobe, 1'b1);
        rst = 1'b0;
        lvl_m = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 line low after reset", line_out, 1'b0);
        check("R1 strobe high after reset", bit_strobe, 1'b1);
        xmit(2'b01, 1'b0, "R1 NRZI zero after reset");
    endtask

    task automatic t_nrz();
        xmit(2'b00, 1'b1, "R4 NRZ one");
        xmit(2'b00, 1'b0, "R4 NRZ zero");
        xmit(2'b00, 1'b1, "R4 NRZ one again");
    endtask

    task automatic t_nrzi();
        xmit(2'b01, 1'b1, "R6 NRZI one toggles");
        xmit(2'b01, 1'b0, "R5 NRZI zero holds high");
        xmit(2'b01, 1'b1, "R6 NRZI one toggles back");
        xmit(2'b01, 1'b0, "R5 NRZI zero holds low");
        xmit(2'b01, 1'b1, "R6 NRZI one");
        xmit(2'b01, 1'b1, "R6 NRZI one twice");
    endtask

    task automatic t_rz();
        xmit(2'b10, 1'b0, "R7 RZ zero");
        xmit(2'b10, 1'b1, "R8 RZ one");
        xmit(2'b10, 1'b1, "R8 RZ one repeated");
        xmit(2'b10, 1'b0, "R7 RZ zero after one");
    endtask

    task automatic t_manch();
        xmit(2'b11, 1'b0, "R9 Manchester zero");
        xmit(2'b11, 1'b1, "R9 Manchester one");
        xmit(2'b11, 1'b1, "R9 Manchester one repeated");
        xmit(2'b11, 1'b0, "R9 Manchester zero after one");
    endtask

    // NRZ one, then switch to RZ with data 0 halfway through the bit.
    task automatic t_midbit();
        check("R2 strobe before mid-bit test", bit_strobe, 1'b1);
        mode = 2'b00; nrz_in = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R10 first half", line_out, 1'b1);
        mode = 2'b10; nrz_in = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R10 second half unaffected", line_out, 1'b1);
        // Manchester one, then flip the data halfway through.
        mode = 2'b11; nrz_in = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R10 Manchester first half", line_out, 1'b1);
        nrz_in = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R10 Manchester second half unaffected", line_out, 1'b0);
    endtask

    task automatic t_retain();
        do_reset();
        xmit(2'b01, 1'b1, "R6 NRZI set level high");
        xmit(2'b10, 1'b1, "R11 RZ between NRZI");
        xmit(2'b11, 1'b0, "R11 Manchester between NRZI");
        xmit(2'b00, 1'b0, "R11 NRZ zero between NRZI");
        xmit(2'b01, 1'b0, "R11 NRZI level kept high");
        xmit(2'b01, 1'b1, "R11 NRZI toggles from kept level");
    endtask

    task automatic t_reset_mid();
        xmit(2'b01, 1'b1, "R6 NRZI level high before reset");
        do_reset();
        xmit(2'b01, 1'b0, "R1 NRZI level cleared by reset");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_nrz();
        t_nrzi();
        t_rz();
        t_manch();
        t_midbit();
        t_retain();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule